// File: doc/BRIEF.md
# Two-row 2x2 window convolution engine

This block is the compute core of a streaming image filter. Each beat carries one word of packed unsigned 8-bit pixels from an upper image row and one word from the row directly below it, both covering the same eight columns. The engine applies a fixed 2x2 kernel to every horizontal window that fits inside that pair of words. The kernel weights the top-left and bottom-right pixels by 1 and the top-right and bottom-left pixels by 2. The seven results come out together in one output beat, each reduced to 8 bits.

The right-hand column of both rows is kept from one accepted beat to the next. This lets one extra lane report the window that straddles two consecutive words of the same row. A start-of-row marker on the input breaks that chain. The multiplications by two are pure wiring shifts, so each lane costs only a few adders. The pipeline is two registers deep and stalls as a unit under output backpressure. Addressing, frame storage, row sequencing and control stay outside the block.

Top module: `quad_conv_engine`

## Requirements
- R1: After reset, out_valid is 0, out_lane_vld is all zero and in_ready is 1.
- R2: Pixel p of a row word occupies bits [8p+7:8p], with pixel 0 the leftmost column. For k = 0..6, output byte k (bits [8k+7:8k]) equals (U[k] + 2*U[k+1] + 2*L[k] + L[k+1]) mod 256, where U is the upper word and L the lower word of the same beat.
- R3: Results wrap modulo 256 with no saturation; all-255 inputs give 250 in every valid lane.
- R4: Output byte 7 is the seam lane. It equals (Up[7] + 2*U[0] + 2*Lp[7] + L[0]) mod 256, where Up and Lp are the words of the previous accepted beat, and its valid bit (out_lane_vld[7]) is set when the beat is not a row start.
- R5: The seam lane valid bit is 0 for a beat accepted with in_sor = 1, and for the first beat accepted after reset.
- R6: Whenever out_valid is 1, out_lane_vld[6:0] are all 1; whenever out_valid is 0, out_lane_vld is all zero.
- R7: A beat accepted in cycle c (in_valid and in_ready high at the rising edge ending c) appears on the outputs in cycle c+2 when out_ready stays high.
- R8: While out_valid is 1 and out_ready is 0, out_data and out_lane_vld hold their values and out_valid stays 1; every accepted beat is delivered once, in order.
- R9: in_ready is 0 exactly when out_valid is 1 and out_ready is 0.
- R10: Words presented while in_valid is 0 do not change the seam lane of the next accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair is present |
| in_ready | output | 1 | Engine takes the input pair at this edge |
| in_sor | input | 1 | Beat is the first of a new row pair |
| in_upper | input | 64 | Eight pixels of the upper row, pixel 0 in the low byte |
| in_lower | input | 64 | Eight pixels of the lower row, pixel 0 in the low byte |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 64 | Eight 8-bit results, lane k at byte k, seam lane at byte 7 |
| out_lane_vld | output | 8 | Per-lane valid bits |

## Verification
Every result is due two cycles after the cycle in which its input pair was accepted. It stays on the outputs for as long as the consumer withholds out_ready. The driver decides acceptance at the falling edge before the capturing rising edge and records that cycle with the expected lanes. The monitor samples at falling edges and checks the exact two-cycle distance for beats sent while out_ready is held high. Under random backpressure it checks only order, content and hold stability.

// File: rtl/quad_conv_pkg.sv
`timescale 1ns/1ps
package quad_conv_pkg;

   // Adder arrangement inside one window lane
   typedef enum logic {
      TREE_CHAIN    = 1'b0,
      TREE_BALANCED = 1'b1
   } tree_e;

   // Left shift applied to the anti-diagonal taps (weight two)
   localparam int ANTI_DIAG_SHIFT = 1;

   // Lane index that carries the window straddling two words
   function automatic int seam_lane(input int lanes);
      return lanes - 1;
   endfunction

endpackage

// File: rtl/qc_window_sum.sv
`timescale 1ns/1ps
module qc_window_sum
   import quad_conv_pkg::*;
#(
   parameter int    PIX_W = 8,
   parameter tree_e TREE  = TREE_BALANCED
) (
   input  logic [PIX_W-1:0] tl_i,
   input  logic [PIX_W-1:0] tr_i,
   input  logic [PIX_W-1:0] bl_i,
   input  logic [PIX_W-1:0] br_i,
   output logic [PIX_W-1:0] res_o
);

   if (PIX_W < 1) begin : g_bad_width
      $error("qc_window_sum: PIX_W must be at least 1");
   end

   // Only the low PIX_W bits of the sum are kept, so every adder is
   // PIX_W wide; the carries above that would be discarded anyway.
   if (TREE == TREE_BALANCED) begin : g_balanced
      logic [PIX_W-1:0] diag_sum;
      logic [PIX_W-1:0] anti_sum;
      always_comb begin
         diag_sum = tl_i + br_i;
         anti_sum = tr_i + bl_i;
         res_o    = diag_sum + (anti_sum << ANTI_DIAG_SHIFT);
      end
   end else begin : g_chain
      logic [PIX_W-1:0] acc_a;
      logic [PIX_W-1:0] acc_b;
      always_comb begin
         acc_a = tl_i + (tr_i << ANTI_DIAG_SHIFT);
         acc_b = acc_a + (bl_i << ANTI_DIAG_SHIFT);
         res_o = acc_b + br_i;
      end
   end

endmodule

// File: rtl/qc_seam_carry.sv
`timescale 1ns/1ps
module qc_seam_carry #(
   parameter int PIX_W     = 8,
   parameter bit SEAM_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             sor_i,
   input  logic [PIX_W-1:0] up_last_i,
   input  logic [PIX_W-1:0] lo_last_i,
   output logic [PIX_W-1:0] prev_up_o,
   output logic [PIX_W-1:0] prev_lo_o,
   output logic             seam_ok_o
);

   if (SEAM_EN) begin : g_carry
      logic [PIX_W-1:0] held_up;
      logic [PIX_W-1:0] held_lo;
      logic             held_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_up <= '0;
            held_lo <= '0;
            held_ok <= 1'b0;
         end else if (accept_i) begin
            held_up <= up_last_i;
            held_lo <= lo_last_i;
            held_ok <= 1'b1;
         end
      end

      assign prev_up_o = held_up;
      assign prev_lo_o = held_lo;
      assign seam_ok_o = held_ok && !sor_i;
   end else begin : g_no_carry
      logic unused_in;
      assign unused_in = ^{clk, rst_n, accept_i, sor_i, up_last_i, lo_last_i};
      assign prev_up_o = '0;
      assign prev_lo_o = '0;
      assign seam_ok_o = 1'b0;
   end

endmodule

// File: rtl/qc_stage_reg.sv
`timescale 1ns/1ps
module qc_stage_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         valid_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);

   if (W < 1) begin : g_bad_width
      $error("qc_stage_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (en_i) begin
         valid_o <= valid_i;
         data_o  <= data_i;
      end
   end

endmodule

// File: rtl/quad_conv_engine.sv
`timescale 1ns/1ps
module quad_conv_engine
   import quad_conv_pkg::*;
#(
   parameter int    PIX_W   = 8,
   parameter int    LANES   = 8,
   parameter bit    SEAM_EN = 1'b1,
   parameter tree_e TREE    = TREE_BALANCED
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic                   in_sor,
   input  logic [PIX_W*LANES-1:0] in_upper,
   input  logic [PIX_W*LANES-1:0] in_lower,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [PIX_W*LANES-1:0] out_data,
   output logic [LANES-1:0]       out_lane_vld
);

   localparam int WORD_W = PIX_W * LANES;
   localparam int SEAM   = seam_lane(LANES);
   localparam int S1_W   = 2 * WORD_W + 2 * PIX_W + 1;
   localparam int S2_W   = WORD_W + LANES;

   if (PIX_W < 2) begin : g_bad_pix
      $error("quad_conv_engine: PIX_W must be at least 2");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("quad_conv_engine: LANES must be at least 2");
   end

   // ---------------- flow control ----------------
   logic advance;
   logic accept;
   logic s2_valid;

   assign advance  = !s2_valid || out_ready;
   assign accept   = in_valid && advance;
   assign in_ready = advance;

   // ---------------- column carry ----------------
   logic [PIX_W-1:0] prev_up;
   logic [PIX_W-1:0] prev_lo;
   logic             seam_ok;

   qc_seam_carry #(
      .PIX_W   (PIX_W),
      .SEAM_EN (SEAM_EN)
   ) u_carry (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .sor_i     (in_sor),
      .up_last_i (in_upper[WORD_W-1 -: PIX_W]),
      .lo_last_i (in_lower[WORD_W-1 -: PIX_W]),
      .prev_up_o (prev_up),
      .prev_lo_o (prev_lo),
      .seam_ok_o (seam_ok)
   );

   // ---------------- stage 1: input capture ----------------
   logic [S1_W-1:0] s1_d;
   logic [S1_W-1:0] s1_q;
   logic            s1_valid;

   assign s1_d = {seam_ok, prev_lo, prev_up, in_lower, in_upper};

   qc_stage_reg #(.W(S1_W)) u_stage_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (advance),
      .valid_i (in_valid),
      .data_i  (s1_d),
      .valid_o (s1_valid),
      .data_o  (s1_q)
   );

   logic [WORD_W-1:0] s1_up;
   logic [WORD_W-1:0] s1_lo;
   logic [PIX_W-1:0]  s1_pup;
   logic [PIX_W-1:0]  s1_plo;
   logic              s1_seam;

   assign s1_up   = s1_q[WORD_W-1:0];
   assign s1_lo   = s1_q[2*WORD_W-1:WORD_W];
   assign s1_pup  = s1_q[2*WORD_W +: PIX_W];
   assign s1_plo  = s1_q[2*WORD_W+PIX_W +: PIX_W];
   assign s1_seam = s1_q[S1_W-1];

   // ---------------- window adders ----------------
   logic [WORD_W-1:0] lane_res;

   for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
      qc_window_sum #(
         .PIX_W (PIX_W),
         .TREE  (TREE)
      ) u_win (
         .tl_i  (s1_up[k*PIX_W +: PIX_W]),
         .tr_i  (s1_up[(k+1)*PIX_W +: PIX_W]),
         .bl_i  (s1_lo[k*PIX_W +: PIX_W]),
         .br_i  (s1_lo[(k+1)*PIX_W +: PIX_W]),
         .res_o (lane_res[k*PIX_W +: PIX_W])
      );
   end

   if (SEAM_EN) begin : g_seam
      qc_window_sum #(
         .PIX_W (PIX_W),
         .TREE  (TREE)
      ) u_seam_win (
         .tl_i  (s1_pup),
         .tr_i  (s1_up[0 +: PIX_W]),
         .bl_i  (s1_plo),
         .br_i  (s1_lo[0 +: PIX_W]),
         .res_o (lane_res[SEAM*PIX_W +: PIX_W])
      );
   end else begin : g_no_seam
      logic unused_prev;
      assign unused_prev = ^{s1_pup, s1_plo};
      assign lane_res[SEAM*PIX_W +: PIX_W] = '0;
   end

   // ---------------- stage 2: result register ----------------
   logic [LANES-1:0] s2_mask_d;
   logic [S2_W-1:0]  s2_d;
   logic [S2_W-1:0]  s2_q;

   always_comb begin
      if (s1_valid) begin
         s2_mask_d       = '1;
         s2_mask_d[SEAM] = s1_seam;
      end else begin
         s2_mask_d = '0;
      end
   end

   assign s2_d = {s2_mask_d, lane_res};

   qc_stage_reg #(.W(S2_W)) u_stage_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (advance),
      .valid_i (s1_valid),
      .data_i  (s2_d),
      .valid_o (s2_valid),
      .data_o  (s2_q)
   );

   assign out_valid    = s2_valid;
   assign out_data     = s2_q[WORD_W-1:0];
   assign out_lane_vld = s2_q[S2_W-1:WORD_W];

endmodule

// File: rtl/quad_conv_engine_chk.sv
`timescale 1ns/1ps
module quad_conv_engine_chk #(
   parameter int PIX_W = 8,
   parameter int LANES = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   in_sor,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [PIX_W*LANES-1:0] out_data,
   input logic [LANES-1:0]       out_lane_vld
);

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lane_vld))); // R8

   AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> ##2 out_valid); // R7

   AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_lane_vld == '0)); // R6

   AST_INNER_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (&out_lane_vld[LANES-2:0])); // R6

   AST_ROW_START_SEAM: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_valid && in_ready && in_sor) ##1 in_ready) |=> !out_lane_vld[LANES-1]); // R5

endmodule

bind quad_conv_engine quad_conv_engine_chk #(
   .PIX_W (PIX_W),
   .LANES (LANES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_sor       (in_sor),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data),
   .out_lane_vld (out_lane_vld)
);

// File: tb/quad_conv_engine_test.sv
`timescale 1ns/1ps
module quad_conv_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_sor = 1'b0;
   logic [63:0] in_upper = '0;
   logic [63:0] in_lower = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_data;
   logic [7:0]  out_lane_vld;

   quad_conv_engine uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_sor       (in_sor),
      .in_upper     (in_upper),
      .in_lower     (in_lower),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_data     (out_data),
      .out_lane_vld (out_lane_vld)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      logic [63:0] data;
      logic [7:0]  mask;
      int          acc;
      bit          lat;
      string       tag;
   } exp_t;

   exp_t  sb[$];
   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    bp     = 1'b0;
   bit    finished = 1'b0;

   logic [7:0] m_up = '0;
   logic [7:0] m_lo = '0;
   bit         m_have = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      if (rst_n) out_ready = bp ? 1'($urandom % 2) : 1'b1;
   end

   function automatic logic [7:0] win(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c, input logic [7:0] d);
      int s;
      s = int'(a) + 2 * int'(b) + 2 * int'(c) + int'(d);
      return 8'(s % 256);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [63:0] u, input logic [63:0] l, input bit sor,
                       input string tag);
      bit done;
      exp_t e;
      in_upper = u;
      in_lower = l;
      in_sor   = sor;
      in_valid = 1'b1;
      done = 1'b0;
      while (!done) begin
         @(negedge clk);
         if (in_ready) begin
            for (int k = 0; k < 7; k++)
               e.data[8*k +: 8] = win(u[8*k +: 8], u[8*(k+1) +: 8],
                                      l[8*k +: 8], l[8*(k+1) +: 8]);
            e.data[63:56] = win(m_up, u[7:0], m_lo, l[7:0]);
            e.mask = {m_have && !sor, 7'h7f};
            e.acc  = cyc;
            e.lat  = !bp;
            e.tag  = tag;
            sb.push_back(e);
            m_up   = u[63:56];
            m_lo   = l[63:56];
            m_have = 1'b1;
            done   = 1'b1;
         end
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_sor   = 1'b0;
   endtask

   task automatic idle_garbage(input int n);
      for (int i = 0; i < n; i++) begin
         in_upper = {$urandom, $urandom};
         in_lower = {$urandom, $urandom};
         in_sor   = 1'($urandom % 2);
         @(posedge clk);
         #1;
      end
      in_sor = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) begin
         @(posedge clk);
      end
      repeat (4) @(posedge clk);
      #1;
   endtask

   // Monitor / scoreboard
   bit          prev_stall = 1'b0;
   logic [63:0] prev_data;
   logic [7:0]  prev_mask;

   always @(negedge clk) begin
      if (rst_n) begin
         check(in_ready == !(out_valid && !out_ready), "R9", "in_ready rule",
               64'(in_ready), 64'(!(out_valid && !out_ready)));
         if (prev_stall)
            check(out_valid && out_data == prev_data && out_lane_vld == prev_mask,
                  "R8", "hold under stall", out_data, prev_data);
         if (!out_valid)
            check(out_lane_vld == 8'h00, "R6", "idle lane mask", 64'(out_lane_vld), 64'h0);
         if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "unexpected output beat", out_data, 64'h0);
            end else begin
               exp_t e;
               logic [63:0] bm;
               e = sb.pop_front();
               check(out_lane_vld == e.mask, e.mask[7] ? "R6" : "R5", "lane mask",
                     64'(out_lane_vld), 64'(e.mask));
               bm = '0;
               for (int k = 0; k < 8; k++) if (e.mask[k]) bm[8*k +: 8] = 8'hff;
               check((out_data & bm) == (e.data & bm),
                     e.mask[7] ? {e.tag, " R2 R4"} : {e.tag, " R2"}, "lane data",
                     out_data & bm, e.data & bm);
               if (e.lat)
                  check(cyc - e.acc == 2, "R7", "latency", 64'(cyc - e.acc), 64'd2);
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_mask  = out_lane_vld;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
      check(out_lane_vld == 8'h00, "R1", "lane mask after reset", 64'(out_lane_vld), 64'h0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);
      @(posedge clk);
      #1;

      // first beat after reset: seam lane invalid (R5)
      send({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "R5");
      // continuation beats: seam lane valid (R4)
      for (int i = 0; i < 3; i++)
         send({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "R4");
      // row start: seam invalid (R5)
      send({$urandom, $urandom}, {$urandom, $urandom}, 1'b1, "R5");
      // gaps with garbage words: carry must ignore them (R10)
      idle_garbage(3);
      send({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "R10");
      // ramp pattern
      send(64'h0706050403020100, 64'h0f0e0d0c0b0a0908, 1'b0, "R2");
      // random stream with occasional row starts
      for (int i = 0; i < 20; i++) begin
         send({$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 4) == 0, "R2");
         if ((i % 5) == 4) idle_garbage(2);
      end
      // wrap case (R3), then zeros
      send(64'hffffffffffffffff, 64'hffffffffffffffff, 1'b0, "R3");
      send(64'hffffffffffffffff, 64'hffffffffffffffff, 1'b0, "R3");
      send(64'h0, 64'h0, 1'b0, "R2");
      drain();

      // random backpressure (R8)
      bp = 1'b1;
      for (int i = 0; i < 40; i++) begin
         send({$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 5) == 0, "R8");
         if ((i % 7) == 3) idle_garbage(1);
      end
      send(64'hffffffffffffffff, 64'hffffffffffffffff, 1'b0, "R3");
      drain();
      bp = 1'b0;
      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule